// File: doc/BRIEF.md
# Associative Tag Lookup with Least-Recently-Used Replacement

This block is a small associative tag store that sits next to a processing engine and a local scratch memory. The engine presents a 32-bit key. All stored tags are compared with that key in one cycle. The reply carries a hit flag, an entry number and a small per-entry state code. Software uses the entry number as the slot index into its own local memory, so the pair behaves as a cache that software manages. Each engine owns its own copy, and no other engine can see it.

On a hit, the reply names the matching entry. On a miss, the reply names the entry that software should evict. Empty slots are handed out first, lowest index first. Once every slot is filled, the slot that has gone longest without use is named. A hit on an entry makes it the most recent. So does a load into it through the write port. A miss leaves the order unchanged, so software can load the named slot afterwards.

A reply appears one clock after the request. A lookup and a write in the same cycle cannot both be served. The write is performed and the lookup is discarded without a reply.

Top module: `lru_cam`

## Requirements
- R1: While reset is held, and on the cycle after it, `rsp_valid` is 0. Reset leaves every entry empty, so no lookup can hit until an entry has been written.
- R2: A lookup accepted in cycle N (`lkp_req`=1, `wr_en`=0) produces exactly one `rsp_valid` pulse in cycle N+1. A cycle without an accepted lookup produces no pulse in the next cycle.
- R3: On a hit, `rsp_hit`=1, `rsp_idx` is the index of the entry whose stored tag equals the key, and `rsp_state` is that entry's stored state.
- R4: An entry that has never been written never matches, even when the key equals its reset tag value of 0.
- R5: When several valid entries hold the key, the lowest such index is reported.
- R6: On a miss, `rsp_hit`=0 and `rsp_state`=0.
- R7: On a miss while any entry is empty, `rsp_idx` is the lowest empty index.
- R8: On a miss with every entry valid, `rsp_idx` is the entry least recently hit or written.
- R9: A hit makes the matched entry the most recently used. A miss leaves the usage order unchanged, so two back-to-back misses name the same entry.
- R10: A write stores `wr_tag` and `wr_state` into entry `wr_idx`, marks that entry valid, and makes it the most recently used.
- R11: When `wr_en` and `lkp_req` are both 1, the write is carried out and the lookup gets no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lkp_req | input | 1 | Lookup request |
| lkp_key | input | 32 | Key to search for |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 4 | Entry to load |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | State code to store |
| rsp_valid | output | 1 | Lookup reply strobe |
| rsp_hit | output | 1 | Key was found |
| rsp_idx | output | 4 | Matching entry on a hit, eviction slot on a miss |
| rsp_state | output | 4 | State of the matching entry, 0 on a miss |

## Verification
A reference model in the bench keeps its own tags, valid flags and use timestamps. Every reply is predicted from that model.

The lookup patterns each target one distinction:
- A key of 0 against an empty store separates valid-gated matching from raw tag comparison.
- Keys that hit in a partly filled store check the index and state return.
- Misses in a partly filled store, including one with a gap written above the first empty slot, test lowest-empty selection.
- Once the store is full, a chosen series of hits and loads checks that the eviction slot tracks recency and ignores index order.
- A tag duplicated in two entries checks lowest-index priority.
- A lookup that collides with a write checks that the lookup is dropped and the write still lands.

// File: rtl/cam_pkg.sv
// cam_pkg: default sizes shared by the tag lookup block and its helpers.
// Assumes: callers override the defaults only through module parameters.
package cam_pkg;
    localparam int CAM_ENTRIES_DEF = 16;
    localparam int CAM_TAG_W_DEF   = 32;
    localparam int CAM_STATE_W_DEF = 4;

    // Width of an index that addresses n entries (at least one bit).
    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/cam_first_set.sv
// cam_first_set: returns the index of the lowest set bit of vec.
// Assumes: the caller decides separately whether any bit is set; an all-zero vec yields 0.
module cam_first_set #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cam_tag_store.sv
// cam_tag_store: holds the tag, state and valid bit of every entry and compares
// the key against all valid entries in parallel.
// Assumes: wr_idx is below ENTRIES; rd_idx selects the state to return.
module cam_tag_store #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 32,
    parameter int STATE_W = 4,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [STATE_W-1:0] wr_state,
    input  logic [TAG_W-1:0]   cmp_key,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRIES-1:0] match_vec,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [STATE_W-1:0] rd_state
);
    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [STATE_W-1:0] state_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Clear every entry on reset; load the addressed entry on a write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                state_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
                tag_q[i]   <= wr_tag;
                state_q[i] <= wr_state;
            end
        end
    end

    // One comparator per entry, gated by that entry's valid bit.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (tag_q[g] == cmp_key);
    end

    assign valid_vec = valid_q;
    assign rd_state  = state_q[rd_idx];
endmodule

// File: rtl/cam_lru_order.sv
// cam_lru_order: keeps a recency rank per entry (0 = newest, ENTRIES-1 = oldest).
// Assumes: the ranks always form a permutation; a touch moves one entry to rank 0
// and ages every entry that was newer than it by one.
module cam_lru_order #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    output logic [ENTRIES-1:0] newest_vec,
    output logic [ENTRIES-1:0] oldest_vec
);
    localparam logic [IDX_W-1:0] OLDEST_RANK = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rank_q [ENTRIES];
    logic [IDX_W-1:0] touch_rank;

    assign touch_rank = rank_q[touch_idx];

    // Seed the ranks with the index order; on a touch, promote one entry and age the newer ones.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                rank_q[i] <= IDX_W'(i);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(i))
                    rank_q[i] <= '0;
                else if (rank_q[i] < touch_rank)
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    // Decode each rank into a newest flag and an oldest flag.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
        assign newest_vec[g] = (rank_q[g] == '0);
        assign oldest_vec[g] = (rank_q[g] == OLDEST_RANK);
    end
endmodule

// File: rtl/lru_cam.sv
// lru_cam: associative tag lookup with a one-cycle registered reply. A hit returns the
// matching entry and its state. A miss returns the lowest empty entry, or the least
// recently used entry once the store is full.
// Assumes: a write has priority over a lookup in the same cycle, and that lookup is dropped.
module lru_cam #(
    parameter int ENTRIES = cam_pkg::CAM_ENTRIES_DEF,
    parameter int TAG_W   = cam_pkg::CAM_TAG_W_DEF,
    parameter int STATE_W = cam_pkg::CAM_STATE_W_DEF,
    localparam int IDX_W  = cam_pkg::idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lkp_req,
    input  logic [TAG_W-1:0]   lkp_key,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [STATE_W-1:0] wr_state,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [IDX_W-1:0]   rsp_idx,
    output logic [STATE_W-1:0] rsp_state
);
    logic               lkp_go;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] newest_vec;
    logic [ENTRIES-1:0] oldest_vec;
    logic               hit_any;
    logic               free_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   old_idx;
    logic [IDX_W-1:0]   pick_idx;
    logic [STATE_W-1:0] hit_state;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;

    assign lkp_go = lkp_req && !wr_en;

    cam_tag_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .STATE_W (STATE_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_state  (wr_state),
        .cmp_key   (lkp_key),
        .rd_idx    (hit_idx),
        .match_vec (match_vec),
        .valid_vec (valid_vec),
        .rd_state  (hit_state)
    );

    cam_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc  (.vec(match_vec),  .idx(hit_idx));
    cam_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (.vec(~valid_vec), .idx(free_idx));
    cam_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_old_enc  (.vec(oldest_vec), .idx(old_idx));

    assign hit_any  = |match_vec;
    assign free_any = ~&valid_vec;

    // Choose the reported index: the match, else an empty slot, else the oldest entry.
    always_comb begin
        if (hit_any)       pick_idx = hit_idx;
        else if (free_any) pick_idx = free_idx;
        else               pick_idx = old_idx;
    end

    // A write or a lookup hit refreshes the recency of one entry.
    assign touch_en  = wr_en || (lkp_go && hit_any);
    assign touch_idx = wr_en ? wr_idx : hit_idx;

    cam_lru_order #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .newest_vec (newest_vec),
        .oldest_vec (oldest_vec)
    );

    // Register the reply one cycle after an accepted lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_state <= '0;
        end else begin
            rsp_valid <= lkp_go;
            if (lkp_go) begin
                rsp_hit   <= hit_any;
                rsp_idx   <= pick_idx;
                rsp_state <= hit_any ? hit_state : '0;
            end
        end
    end
endmodule

// File: rtl/cam_lru_checker.sv
// cam_lru_checker: temporal properties of the lookup block, attached by bind.
// Assumes: it observes the top-level ports and the recency flags of the rank logic.
module cam_lru_checker #(
    parameter int ENTRIES = 16,
    parameter int STATE_W = 4,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lkp_req,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [STATE_W-1:0] rsp_state,
    input logic [ENTRIES-1:0] newest_vec,
    input logic [ENTRIES-1:0] oldest_vec
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

    // R2
    reply_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && !wr_en) |=> rsp_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_req |=> !rsp_valid);

    // R11
    collide_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && wr_en) |=> !rsp_valid);

    // R6
    miss_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_state == '0));

    // R8
    oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    // R10
    write_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> newest_vec[$past(wr_idx)]);
endmodule

bind lru_cam cam_lru_checker #(
    .ENTRIES (ENTRIES),
    .STATE_W (STATE_W),
    .IDX_W   (IDX_W)
) u_lru_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lkp_req    (lkp_req),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_state  (rsp_state),
    .newest_vec (newest_vec),
    .oldest_vec (oldest_vec)
);

// File: tb/lru_cam_test.sv
// lru_cam_test: scoreboard bench. Driver tasks update a reference model and queue the
// expected reply; a monitor pops and compares on every reply strobe.
module lru_cam_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_req = 1'b0;
    logic [31:0] lkp_key = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_tag = '0;
    logic [3:0]  wr_state = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [3:0]  rsp_idx;
    logic [3:0]  rsp_state;

    lru_cam uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_req   (lkp_req),
        .lkp_key   (lkp_key),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_state  (wr_state),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_idx   (rsp_idx),
        .rsp_state (rsp_state)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [8:0] val;   // {hit, idx, state}
        string      req;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;

    bit          m_valid [ENTRIES];
    logic [31:0] m_tag   [ENTRIES];
    logic [3:0]  m_state [ENTRIES];
    int          m_stamp [ENTRIES];
    int          now_stamp = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic touch(input int i);
        now_stamp++;
        m_stamp[i] = now_stamp;
    endtask

    task automatic model_write(input int i, input logic [31:0] tag, input logic [3:0] st);
        m_valid[i] = 1'b1;
        m_tag[i]   = tag;
        m_state[i] = st;
        touch(i);
    endtask

    // Driver: load one entry (R10).
    task automatic do_write(input int i, input logic [31:0] tag, input logic [3:0] st);
        model_write(i, tag, st);
        wr_en = 1'b1; wr_idx = 4'(i); wr_tag = tag; wr_state = st;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: one lookup, predicted by the model and queued for the monitor.
    task automatic do_lookup(input logic [31:0] key, input string req);
        exp_t e;
        logic hit;
        logic [3:0] idx;
        logic [3:0] st;
        int best;
        hit = 1'b0; idx = '0; st = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (m_valid[i] && m_tag[i] == key) begin
                hit = 1'b1; idx = 4'(i); st = m_state[i];
            end
        end
        if (hit) begin
            touch(int'(idx));
        end else begin
            best = -1;
            for (int i = 0; i < ENTRIES; i++)
                if (!m_valid[i] && best < 0) best = i;
            if (best < 0) begin
                best = 0;
                for (int i = 1; i < ENTRIES; i++)
                    if (m_stamp[i] < m_stamp[best]) best = i;
            end
            idx = 4'(best);
        end
        e.val = {hit, idx, st};
        e.req = req;
        exp_q.push_back(e);
        lkp_req = 1'b1; lkp_key = key;
        @(negedge clk);
        lkp_req = 1'b0;
    endtask

    // Monitor: every reply must match the oldest queued prediction (R2).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected reply", 32'(rsp_valid), 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, 32'({rsp_hit, rsp_idx, rsp_state}), 32'(e.val));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_state[i] = '0; m_stamp[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 reply strobe during reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reply strobe after reset", 32'(rsp_valid), 32'd0);

        // R4 R7: key 0 against an empty store misses and names slot 0.
        do_lookup(32'h0, "R4 stale zero tag must not hit");

        // R10: fill slots 0..3.
        for (int i = 0; i < 4; i++) do_write(i, 32'hA000_0000 + i, 4'(i + 1));

        // R3 R2: back-to-back hits.
        do_lookup(32'hA000_0002, "R3 hit slot 2");
        do_lookup(32'hA000_0000, "R3 hit slot 0");
        do_lookup(32'hA000_0001, "R3 hit slot 1");
        do_lookup(32'hA000_0003, "R3 hit slot 3");

        // R6 R7: miss names the lowest empty slot.
        do_lookup(32'h1234_5678, "R7 miss lowest empty");
        do_write(9, 32'hB900_0009, 4'hC);
        do_lookup(32'h1234_5678, "R7 miss lowest empty after gap");
        do_lookup(32'hB900_0009, "R10 written tag and state returned");

        // Fill the rest of the store.
        for (int i = 4; i < ENTRIES; i++)
            if (i != 9) do_write(i, 32'hC000_0000 + i, 4'(i));

        // R8 R9: least recently used selection and update.
        do_lookup(32'hDEAD_0001, "R8 miss full store names oldest");
        do_lookup(32'hDEAD_0002, "R9 second miss names same slot");
        do_lookup(32'hA000_0002, "R3 hit refreshes slot 2");
        do_lookup(32'hDEAD_0003, "R9 oldest moves after hit");
        do_write(0, 32'hE000_0000, 4'h7);
        do_lookup(32'hDEAD_0004, "R10 write refreshes recency");

        // R5: duplicate tag reports the lower slot.
        do_write(12, 32'hD0D0_D0D0, 4'h3);
        do_write(5,  32'hD0D0_D0D0, 4'h9);
        do_lookup(32'hD0D0_D0D0, "R5 lowest matching slot");
        do_write(5, 32'hF555_0005, 4'h1);
        do_lookup(32'hD0D0_D0D0, "R5 remaining duplicate");

        // R11: a lookup colliding with a write is dropped; the write lands.
        model_write(7, 32'h7777_7777, 4'h6);
        wr_en = 1'b1; wr_idx = 4'd7; wr_tag = 32'h7777_7777; wr_state = 4'h6;
        lkp_req = 1'b1; lkp_key = 32'h7777_7777;
        @(negedge clk);
        wr_en = 1'b0; lkp_req = 1'b0;
        check("R11 no reply for colliding lookup", 32'(rsp_valid), 32'd0);
        do_lookup(32'h7777_7777, "R11 colliding write landed");
        do_lookup(32'hDEAD_0005, "R8 oldest after collision");

        repeat (3) @(negedge clk);
        check("R2 every lookup answered", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule